// File: doc/BRIEF.md
# Predicate Mask Fetch Unit

This unit turns an operand's register number into the per-element predicate mask that governs a vectorised operation. For each request it checks two per-register tables, chosen by the operand's class (integer or floating-point): a redirection table that says whether the register is redirected at all, and a predicate table. Each predicate entry holds an enable, an invert bit, a zeroing bit and the number of an integer register that holds the mask bits.

When both entries are enabled, the unit drives the predicate entry's register number onto the integer register file read port. It takes the XLEN-bit value back in the same cycle and inverts it if the entry asks for that. When either entry is disabled, the mask is all ones, so every element runs. The unit also reports the zeroing mode and a single enable bit for a supplied element offset. Both tables are loaded through a simple write port. Results appear one clock after the request.

Top module: `pmf_fetch_top`

## Requirements
- R1: After synchronous reset, out_valid is 0 and every table entry is disabled, so any request yields mask_out all ones and zero_out 0.
- R2: If the operand's redirection entry is disabled, mask_out is all ones and zero_out is 0, whatever its predicate entry holds.
- R3: If the redirection entry is enabled but the predicate entry is disabled, mask_out is all ones and zero_out is 0.
- R4: If both entries are enabled and invert is clear, rf_raddr equals the predicate entry's register field during the request cycle, and mask_out equals the rf_rdata returned in that cycle.
- R5: If both entries are enabled and invert is set, mask_out is the bitwise complement of the returned rf_rdata.
- R6: If both entries are enabled, zero_out equals the predicate entry's zeroing bit.
- R7: Integer (req_fp=0) and floating-point (req_fp=1) operands use separate redirection and predicate tables. A write to one class never changes the results for the other.
- R8: elem_en is bit N of mask_out, where N is the registered element offset.
- R9: An element offset of XLEN or more gives elem_en 0.
- R10: out_valid is high in exactly the cycles that follow a cycle with req_valid high. mask_out, zero_out and elem_en then show that request's result.
- R11: A table write with cfg_we high takes effect for requests made from the next cycle onward. cfg_pred=1 selects the predicate table and cfg_pred=0 the redirection table; cfg_fp selects the class. Predicate data bits [4:0] are the register number, bit 5 is zeroing, bit 6 is invert and bit 7 is enable. For a redirection write only bit 0 (enable) is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_pred | input | 1 | 1: predicate table, 0: redirection table |
| cfg_fp | input | 1 | Class of the table written (1 = floating-point) |
| cfg_reg | input | 5 | Register number of the entry written |
| cfg_data | input | 8 | Entry data |
| req_valid | input | 1 | Mask request strobe |
| req_fp | input | 1 | Operand class of the request |
| req_reg | input | 5 | Operand register number |
| req_elem | input | EOFF_W | Element offset to test |
| rf_raddr | output | 5 | Integer register file read address |
| rf_rdata | input | XLEN | Integer register file read data (same cycle) |
| out_valid | output | 1 | Result valid |
| mask_out | output | XLEN | Final predicate mask |
| zero_out | output | 1 | Zeroing mode of the operand |
| elem_en | output | 1 | Enable of the requested element |

## Verification
A corrupted table entry appears on the very next result. The mask either falls back to all ones or shows the wrong register's bits, complemented or not, and the zeroing bit may be wrong. A bank mix-up between the classes shows up as soon as an integer and a floating-point operand with different settings are requested in turn. A fault in the output stage shows up on the following cycle's out_valid or elem_en. The sweep programs every entry of both classes with distinct settings and then requests every register at every element offset, including offsets beyond XLEN, so each of these faults is seen within one request of the bad state.

// File: rtl/pmf_pkg.sv
package pmf_pkg;
    localparam int RIDX_W  = 5;
    localparam int NREG    = 1 << RIDX_W;
    localparam int ENTRY_W = RIDX_W + 3;

    typedef struct packed {
        logic              enable;
        logic              invert;
        logic              zeroing;
        logic [RIDX_W-1:0] src;
    } pred_ent_t;

    function automatic pred_ent_t to_pred(input logic [ENTRY_W-1:0] raw);
        return pred_ent_t'(raw);
    endfunction
endpackage

// File: rtl/pmf_table.sv
module pmf_table
    import pmf_pkg::*;
#(
    parameter int W = ENTRY_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              wbank,
    input  logic [RIDX_W-1:0] waddr,
    input  logic [W-1:0]      wdata,
    input  logic              rbank,
    input  logic [RIDX_W-1:0] raddr,
    output logic [W-1:0]      rdata
);
    logic [W-1:0] bank_rd [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [W-1:0] ent [NREG];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < NREG; i++) ent[i] <= '0;
            end else if (we && (wbank == b[0])) begin
                ent[waddr] <= wdata;
            end
        end
        assign bank_rd[b] = ent[raddr];
    end

    assign rdata = bank_rd[rbank];
endmodule

// File: rtl/pmf_mask_form.sv
module pmf_mask_form
    import pmf_pkg::*;
#(
    parameter int XLEN = 16
) (
    input  logic            redir_on,
    input  pred_ent_t       pent,
    input  logic [XLEN-1:0] rf_val,
    output logic [XLEN-1:0] mask,
    output logic            zero
);
    always_comb begin
        mask = '1;
        zero = 1'b0;
        if (redir_on && pent.enable) begin
            mask = pent.invert ? ~rf_val : rf_val;
            zero = pent.zeroing;
        end
    end
endmodule

// File: rtl/pmf_elem_sel.sv
module pmf_elem_sel #(
    parameter int XLEN   = 16,
    parameter int EOFF_W = $clog2(XLEN) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [XLEN-1:0]   mask,
    input  logic [EOFF_W-1:0] off,
    output logic              en
);
    logic in_range;
    assign in_range = ({{(32-EOFF_W){1'b0}}, off} < XLEN);
    always_comb begin
        en = 1'b0;
        for (int i = 0; i < XLEN; i++)
            if (in_range && (off == EOFF_W'(i))) en = mask[i];
    end

    // R8: an enabled element always has its mask bit set
    assert_en_has_bit_R8: assert property (@(posedge clk) disable iff (rst)
        en |-> (in_range && mask[off[EOFF_W-2:0]]));
endmodule

// File: rtl/pmf_fetch_top.sv
module pmf_fetch_top
    import pmf_pkg::*;
#(
    parameter int XLEN   = 16,
    parameter int EOFF_W = $clog2(XLEN) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_pred,
    input  logic              cfg_fp,
    input  logic [4:0]        cfg_reg,
    input  logic [7:0]        cfg_data,
    input  logic              req_valid,
    input  logic              req_fp,
    input  logic [4:0]        req_reg,
    input  logic [EOFF_W-1:0] req_elem,
    output logic [4:0]        rf_raddr,
    input  logic [XLEN-1:0]   rf_rdata,
    output logic              out_valid,
    output logic [XLEN-1:0]   mask_out,
    output logic              zero_out,
    output logic              elem_en
);
    logic [0:0]         redir_raw;
    logic [ENTRY_W-1:0] pred_raw;
    pred_ent_t          pent;
    logic [XLEN-1:0]    mask_d;
    logic               zero_d;
    logic [EOFF_W-1:0]  off_q;

    pmf_table #(.W(1)) redir_tbl_i (
        .clk(clk), .rst(rst), .we(cfg_we && !cfg_pred), .wbank(cfg_fp),
        .waddr(cfg_reg), .wdata(cfg_data[0]), .rbank(req_fp),
        .raddr(req_reg), .rdata(redir_raw)
    );

    pmf_table #(.W(ENTRY_W)) pred_tbl_i (
        .clk(clk), .rst(rst), .we(cfg_we && cfg_pred), .wbank(cfg_fp),
        .waddr(cfg_reg), .wdata(cfg_data), .rbank(req_fp),
        .raddr(req_reg), .rdata(pred_raw)
    );

    assign pent     = to_pred(pred_raw);
    assign rf_raddr = pent.src;

    pmf_mask_form #(.XLEN(XLEN)) form_i (
        .redir_on(redir_raw[0]), .pent(pent), .rf_val(rf_rdata),
        .mask(mask_d), .zero(zero_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            mask_out  <= '1;
            zero_out  <= 1'b0;
            off_q     <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                mask_out <= mask_d;
                zero_out <= zero_d;
                off_q    <= req_elem;
            end
        end
    end

    pmf_elem_sel #(.XLEN(XLEN), .EOFF_W(EOFF_W)) sel_i (
        .clk(clk), .rst(rst), .mask(mask_out), .off(off_q), .en(elem_en)
    );

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);
    assert_valid_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);
    assert_redir_off_ones_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !redir_raw[0]) |=> (mask_out == '1 && !zero_out));
    assert_pred_off_ones_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && redir_raw[0] && !pent.enable) |=> (mask_out == '1 && !zero_out));
    assert_plain_mask_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && redir_raw[0] && pent.enable && !pent.invert)
            |=> (mask_out == $past(rf_rdata)));
    assert_inverted_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && redir_raw[0] && pent.enable && pent.invert)
            |=> (mask_out == ~$past(rf_rdata)));
    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && redir_raw[0] && pent.enable) |=> (zero_out == $past(pent.zeroing)));
    assert_far_elem_off_R9: assert property (@(posedge clk) disable iff (rst)
        ({{(32-EOFF_W){1'b0}}, off_q} >= XLEN) |-> !elem_en);
endmodule

// File: tb/pmf_fetch_top_tb_top.sv
module pmf_fetch_top_tb_top;
    localparam int XLEN   = 16;
    localparam int EOFF_W = $clog2(XLEN) + 1;

    logic clk = 1'b0;
    logic rst;
    logic cfg_we, cfg_pred, cfg_fp;
    logic [4:0] cfg_reg;
    logic [7:0] cfg_data;
    logic req_valid, req_fp;
    logic [4:0] req_reg;
    logic [EOFF_W-1:0] req_elem;
    logic [4:0] rf_raddr;
    logic [XLEN-1:0] rf_rdata;
    logic out_valid, zero_out, elem_en;
    logic [XLEN-1:0] mask_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    function automatic logic [XLEN-1:0] rf_val(input logic [4:0] a);
        return XLEN'((int'(a) * 16'h1357) ^ 16'hA5C3);
    endfunction
    assign rf_rdata = rf_val(rf_raddr);

    // configuration model: function of class and register
    function automatic bit m_redir(input bit fp, input int r);
        return fp ? (r % 3 != 1) : (r % 3 != 0);
    endfunction
    function automatic bit m_pen(input bit fp, input int r);
        return fp ? (r % 4 != 2) : (r % 4 != 1);
    endfunction
    function automatic bit m_inv(input bit fp, input int r);
        return ((r >> 1) & 1) != int'(fp);
    endfunction
    function automatic bit m_zero(input bit fp, input int r);
        return ((r >> 2) & 1) == int'(fp);
    endfunction
    function automatic logic [4:0] m_src(input bit fp, input int r);
        return 5'((r * 7 + (fp ? 3 : 0)) % 32);
    endfunction

    pmf_fetch_top #(.XLEN(XLEN), .EOFF_W(EOFF_W)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_pred(cfg_pred),
        .cfg_fp(cfg_fp), .cfg_reg(cfg_reg), .cfg_data(cfg_data),
        .req_valid(req_valid), .req_fp(req_fp), .req_reg(req_reg),
        .req_elem(req_elem), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .out_valid(out_valid), .mask_out(mask_out), .zero_out(zero_out),
        .elem_en(elem_en)
    );

    task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input bit pred, input bit fp, input int r, input logic [7:0] d);
        cfg_we = 1; cfg_pred = pred; cfg_fp = fp; cfg_reg = 5'(r); cfg_data = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // one request: drive, check address, advance, check outputs
    task automatic request(input bit fp, input int r, input int off,
                           input bit ra, input bit pa, input bit inv, input bit zr,
                           input logic [4:0] src);
        logic [XLEN-1:0] em;
        bit ez, een;
        string tg;
        req_valid = 1; req_fp = fp; req_reg = 5'(r); req_elem = EOFF_W'(off);
        #1;
        if (ra && pa) check("R4 rf_raddr", XLEN'(rf_raddr), XLEN'(src));
        @(negedge clk);
        req_valid = 0;
        if (!ra) begin em = '1; ez = 0; tg = "R2"; end
        else if (!pa) begin em = '1; ez = 0; tg = "R3"; end
        else begin
            em = inv ? ~rf_val(src) : rf_val(src);
            ez = zr;
            tg = inv ? "R5/R6" : "R4/R6";
        end
        een = (off < XLEN) ? em[off] : 1'b0;
        check({tg, " R7 mask"}, mask_out, em);
        check({tg, " zero"}, XLEN'(zero_out), XLEN'(ez));
        check((off < XLEN) ? "R8 elem_en" : "R9 elem_en", XLEN'(elem_en), XLEN'(een));
        check("R10 out_valid", XLEN'(out_valid), XLEN'(1));
    endtask

    initial begin
        rst = 1; cfg_we = 0; cfg_pred = 0; cfg_fp = 0; cfg_reg = 0; cfg_data = 0;
        req_valid = 0; req_fp = 0; req_reg = 0; req_elem = 0;
        repeat (3) @(negedge clk);
        check("R1 out_valid", XLEN'(out_valid), XLEN'(0));
        rst = 0;
        // R1: tables empty after reset
        for (int fp = 0; fp < 2; fp++)
            for (int r = 0; r < 32; r += 5)
                request(fp[0], r, r % XLEN, 0, 0, 0, 0, 0);
        @(negedge clk);
        check("R10 idle out_valid", XLEN'(out_valid), XLEN'(0));
        // program both classes (R11 field layout)
        for (int fp = 0; fp < 2; fp++)
            for (int r = 0; r < 32; r++) begin
                cfg_write(0, fp[0], r, {7'h55, m_redir(fp[0], r)});
                cfg_write(1, fp[0], r, {m_pen(fp[0], r), m_inv(fp[0], r),
                                        m_zero(fp[0], r), m_src(fp[0], r)});
            end
        // full sweep, classes interleaved (R7)
        for (int r = 0; r < 32; r++)
            for (int off = 0; off < XLEN + 2; off++)
                for (int fp = 0; fp < 2; fp++)
                    request(fp[0], r, off, m_redir(fp[0], r), m_pen(fp[0], r),
                            m_inv(fp[0], r), m_zero(fp[0], r), m_src(fp[0], r));
        // R11: a write is seen by a request in the next cycle; other class unchanged (R7)
        cfg_write(1, 0, 3, {1'b1, 1'b0, 1'b1, 5'd9});
        request(0, 3, 0, m_redir(0, 3), 1, 0, 1, 5'd9);
        request(1, 3, 0, m_redir(1, 3), m_pen(1, 3), m_inv(1, 3), m_zero(1, 3), m_src(1, 3));
        cfg_write(0, 0, 3, 8'h00);
        request(0, 3, 1, 0, 1, 0, 1, 5'd9);
        request(1, 3, 1, m_redir(1, 3), m_pen(1, 3), m_inv(1, 3), m_zero(1, 3), m_src(1, 3));
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_vec++; n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule